// File: doc/BRIEF.md
# Add-Only Sector Protection Register

This block holds the protection setting for the sectors of a non-volatile data array. The setting is one byte. One flag, the open flag, switches protection off as a whole. A size field picks how many of the lowest-numbered sectors are blocked from program and erase commands. The command logic reads a per-sector vector, `sect_prot`, and refuses any operation on a sector whose bit is high.

During the reset sequence a loader fetches a configuration byte and presents it on the load port. That load replaces the whole setting without restriction. If the fetch reports an uncorrectable error, the register takes the most protective setting instead. After that, software writes on the bus port can only strengthen protection. The open flag can only be cleared, and the size field can only grow. Each field is judged on its own within a write. The read-back port always shows the setting that is in force.

Top module: `prot_ratchet_reg`

## Requirements
- R1: While reset is asserted and right after it is released, before any load, read-back is 0x0F (open flag 0, size 0xF) and all 16 sectors are reported protected.
- R2: Read-back places the open flag at bit 7 and the size field at bits 3:0. Bits 6:4 always read 0, whatever was written or loaded into them.
- R3: A bus write with bit 7 at 0 clears the open flag. A bus write with bit 7 at 1 never sets a cleared open flag back to 1.
- R4: A bus write whose bits 3:0 exceed the stored size replaces the size. A write carrying an equal or smaller value leaves the size unchanged.
- R5: Within one bus write, the open flag and the size are filtered independently, so a legal change to one field takes effect even when the change to the other is refused.
- R6: A load strobe without fault copies bit 7 and bits 3:0 of the load byte into the register, even when this lowers protection.
- R7: A load strobe with the fault input high sets the open flag to 0 and the size to 0xF, whatever the load byte holds.
- R8: A bus write in the same cycle as a load strobe is ignored, and the load result alone appears on read-back.
- R9: While the open flag is 1, no sector is reported protected, whatever the size.
- R10: While the open flag is 0, sector n (bit n of `sect_prot`) is reported protected exactly when n is less than or equal to the size field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Active setting: open flag at bit 7, size at bits 3:0 |
| ld_en | input | 1 | Reset-time load strobe |
| ld_data | input | 8 | Configuration byte being loaded |
| ld_fault | input | 1 | Uncorrectable error on the configuration byte fetch |
| sect_prot | output | 16 | Per-sector protected flags |

## Verification
The write or load strobe is sampled at one rising edge, and the new setting lands in the register at that same edge. Read-back and the sector vector are combinational from the register, so both results are due in the cycle that follows the strobe edge. The bench drives each stimulus on a falling edge and holds it across exactly one rising edge. It withdraws the stimulus and samples `rd_data` and `sect_prot` on the next falling edge, half a period after the update. The reset values are sampled while reset is held and again after release, before any strobe.

// File: rtl/prot_ratchet_pkg.sv
package prot_ratchet_pkg;

   // Source of the next register value in a given cycle
   typedef enum logic [1:0] {
      UPD_HOLD  = 2'd0,
      UPD_WRITE = 2'd1,
      UPD_LOAD  = 2'd2,
      UPD_FAULT = 2'd3
   } upd_src_e;

endpackage

// File: rtl/prot_upd_sel.sv
module prot_upd_sel
   import prot_ratchet_pkg::*;
(
   input  logic     ld_en,
   input  logic     ld_fault,
   input  logic     wr_en,
   output upd_src_e src
);

   // Load has priority over a bus write in the same cycle
   always_comb begin
      if (ld_en)
         src = ld_fault ? UPD_FAULT : UPD_LOAD;
      else if (wr_en)
         src = UPD_WRITE;
      else
         src = UPD_HOLD;
   end

endmodule

// File: rtl/prot_wr_filter.sv
module prot_wr_filter
   import prot_ratchet_pkg::*;
#(
   parameter int SIZE_W = 4
) (
   input  upd_src_e          src,
   input  logic              cur_open,
   input  logic [SIZE_W-1:0] cur_size,
   input  logic              wr_open,
   input  logic [SIZE_W-1:0] wr_size,
   input  logic              ld_open,
   input  logic [SIZE_W-1:0] ld_size,
   output logic              nxt_open,
   output logic [SIZE_W-1:0] nxt_size
);

   localparam logic [SIZE_W-1:0] SIZE_MAX = '1;

   logic              w_open;
   logic [SIZE_W-1:0] w_size;

   // Each field moves only toward more protection, judged on its own
   always_comb begin
      w_open = cur_open & wr_open;
      w_size = (wr_size > cur_size) ? wr_size : cur_size;
   end

   always_comb begin
      unique case (src)
         UPD_WRITE: begin
            nxt_open = w_open;
            nxt_size = w_size;
         end
         UPD_LOAD: begin
            nxt_open = ld_open;
            nxt_size = ld_size;
         end
         UPD_FAULT: begin
            nxt_open = 1'b0;
            nxt_size = SIZE_MAX;
         end
         default: begin
            nxt_open = cur_open;
            nxt_size = cur_size;
         end
      endcase
   end

endmodule

// File: rtl/prot_sector_map.sv
module prot_sector_map #(
   parameter int SIZE_W        = 4,
   parameter bit MASK_BY_SHIFT = 1'b0,
   localparam int NUM_SECT     = 1 << SIZE_W
) (
   input  logic                open,
   input  logic [SIZE_W-1:0]   size,
   output logic [NUM_SECT-1:0] mask
);

   generate
      if (MASK_BY_SHIFT) begin : g_shift
         logic [NUM_SECT:0] one_hot;
         logic [NUM_SECT:0] therm;
         logic              unused_top;
         assign one_hot    = (NUM_SECT+1)'(1) << ({1'b0, size} + (SIZE_W+1)'(1));
         assign therm      = one_hot - (NUM_SECT+1)'(1);
         assign unused_top = therm[NUM_SECT];
         assign mask       = open ? '0 : therm[NUM_SECT-1:0];
      end else begin : g_cmp
         for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
            localparam logic [SIZE_W:0] IDX = (SIZE_W+1)'(i);
            assign mask[i] = !open && (IDX <= {1'b0, size});
         end
      end
   endgenerate

endmodule

// File: rtl/prot_ratchet_reg.sv
module prot_ratchet_reg
   import prot_ratchet_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int SIZE_W        = 4,
   parameter bit MASK_BY_SHIFT = 1'b0,
   localparam int NUM_SECT     = 1 << SIZE_W,
   localparam int OPEN_BIT     = DATA_W - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   rd_data,
   input  logic                ld_en,
   input  logic [DATA_W-1:0]   ld_data,
   input  logic                ld_fault,
   output logic [NUM_SECT-1:0] sect_prot
);

   localparam int GAP_W = OPEN_BIT - SIZE_W;

   generate
      if (SIZE_W < 1 || SIZE_W > 8)
         $error("prot_ratchet_reg: SIZE_W must lie in 1..8");
      if (DATA_W < SIZE_W + 2)
         $error("prot_ratchet_reg: DATA_W must leave at least one unused bit");
   endgenerate

   upd_src_e          src;
   logic              open_q, open_d;
   logic [SIZE_W-1:0] size_q, size_d;
   logic              unused_gap;

   assign unused_gap = ^{wr_data[OPEN_BIT-1:SIZE_W], ld_data[OPEN_BIT-1:SIZE_W]};

   prot_upd_sel u_sel (
      .ld_en    (ld_en),
      .ld_fault (ld_fault),
      .wr_en    (wr_en),
      .src      (src)
   );

   prot_wr_filter #(.SIZE_W(SIZE_W)) u_filt (
      .src      (src),
      .cur_open (open_q),
      .cur_size (size_q),
      .wr_open  (wr_data[OPEN_BIT]),
      .wr_size  (wr_data[SIZE_W-1:0]),
      .ld_open  (ld_data[OPEN_BIT]),
      .ld_size  (ld_data[SIZE_W-1:0]),
      .nxt_open (open_d),
      .nxt_size (size_d)
   );

   // Reset value is the most protective setting until the loader runs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         size_q <= '1;
      end else begin
         open_q <= open_d;
         size_q <= size_d;
      end
   end

   assign rd_data = {open_q, {GAP_W{1'b0}}, size_q};

   prot_sector_map #(
      .SIZE_W        (SIZE_W),
      .MASK_BY_SHIFT (MASK_BY_SHIFT)
   ) u_map (
      .open (open_q),
      .size (size_q),
      .mask (sect_prot)
   );

endmodule

// File: rtl/prot_ratchet_chk.sv
module prot_ratchet_chk #(
   parameter int DATA_W    = 8,
   parameter int SIZE_W    = 4,
   localparam int NUM_SECT = 1 << SIZE_W,
   localparam int OPEN_BIT = DATA_W - 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ld_en,
   input logic                ld_fault,
   input logic [DATA_W-1:0]   ld_data,
   input logic [DATA_W-1:0]   rd_data,
   input logic [NUM_SECT-1:0] sect_prot
);

   logic unused_ld;
   assign unused_ld = ^ld_data[OPEN_BIT-1:SIZE_W];

   assert_gap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[OPEN_BIT-1:SIZE_W] == '0);

   assert_open_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !rd_data[OPEN_BIT]) |=> !rd_data[OPEN_BIT]);

   assert_size_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> rd_data[SIZE_W-1:0] >= $past(rd_data[SIZE_W-1:0]));

   // also covers R8: a concurrent write cannot alter the load result
   assert_load_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !ld_fault) |=>
         (rd_data[OPEN_BIT] == $past(ld_data[OPEN_BIT])) &&
         (rd_data[SIZE_W-1:0] == $past(ld_data[SIZE_W-1:0])));

   assert_fault_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_fault) |=> !rd_data[OPEN_BIT] && (rd_data[SIZE_W-1:0] == '1));

   assert_open_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[OPEN_BIT] |-> sect_prot == '0);

   assert_span_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[OPEN_BIT] |->
         ($countones(sect_prot) == int'(rd_data[SIZE_W-1:0]) + 1) && sect_prot[0]);

endmodule

bind prot_ratchet_reg prot_ratchet_chk #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/prot_ratchet_reg_tb_top.sv
module prot_ratchet_reg_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic        ld_en = 1'b0;
   logic [7:0]  ld_data = '0;
   logic        ld_fault = 1'b0;
   logic [15:0] sect_prot;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   prot_ratchet_reg dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .ld_en     (ld_en),
      .ld_data   (ld_data),
      .ld_fault  (ld_fault),
      .sect_prot (sect_prot)
   );

   function automatic logic [15:0] exp_mask(input logic [7:0] setting);
      logic [16:0] m;
      m = (17'd1 << (int'(setting[3:0]) + 1)) - 17'd1;
      return setting[7] ? 16'h0000 : m[15:0];
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_state(input string req, input logic [7:0] exp);
      check({req, " read-back"}, {8'h00, rd_data}, {8'h00, exp});
      check({req, " sectors"}, sect_prot, exp_mask(exp));
   endtask

   // Drive on a falling edge, hold over one rising edge, sample on the next falling edge
   task automatic step(input logic we, input logic [7:0] wd,
                       input logic le, input logic [7:0] ldd, input logic lf);
      @(negedge clk);
      wr_en = we; wr_data = wd; ld_en = le; ld_data = ldd; ld_fault = lf;
      @(negedge clk);
      wr_en = 1'b0; ld_en = 1'b0; ld_fault = 1'b0;
   endtask

   task automatic bus_write(input logic [7:0] d);
      step(1'b1, d, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic cfg_load(input logic [7:0] d, input logic f);
      step(1'b0, 8'h00, 1'b1, d, f);
   endtask

   task automatic t_reset_R1;
      repeat (3) @(negedge clk);
      check_state("R1 in reset", 8'h0F);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 after release", 8'h0F);
   endtask

   task automatic t_load_R6_R9;
      cfg_load(8'h80, 1'b0);
      check_state("R6 load open", 8'h80);
      bus_write(8'h85);
      check_state("R9 open ignores size", 8'h85);
      step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
      check_state("R9 idle cycle holds", 8'h85);
   endtask

   task automatic t_size_R4;
      bus_write(8'h83);
      check_state("R4 smaller size refused", 8'h85);
      bus_write(8'h85);
      check_state("R4 equal size kept", 8'h85);
   endtask

   task automatic t_open_R3;
      bus_write(8'h05);
      check_state("R3 open cleared", 8'h05);
      bus_write(8'h80);
      check_state("R3 open not set back", 8'h05);
   endtask

   task automatic t_indep_R5;
      bus_write(8'h89);
      check_state("R5 size taken, open refused", 8'h09);
      bus_write(8'h02);
      check_state("R5 both refused", 8'h09);
   endtask

   task automatic t_gap_R2;
      bus_write(8'h72);
      check_state("R2 gap bits with small size", 8'h09);
      bus_write(8'h7C);
      check_state("R2 gap bits read zero", 8'h0C);
      cfg_load(8'hF3, 1'b0);
      check_state("R2 gap bits from load", 8'h83);
   endtask

   task automatic t_bypass_R6;
      bus_write(8'h0F);
      check_state("R6 full protection", 8'h0F);
      cfg_load(8'h82, 1'b0);
      check_state("R6 load lowers protection", 8'h82);
   endtask

   task automatic t_fault_R7;
      cfg_load(8'h80, 1'b1);
      check_state("R7 fault gives maximum", 8'h0F);
   endtask

   task automatic t_collide_R8;
      step(1'b1, 8'h0F, 1'b1, 8'h81, 1'b0);
      check_state("R8 load wins over write", 8'h81);
      step(1'b1, 8'h8A, 1'b1, 8'h04, 1'b1);
      check_state("R8 fault load wins over write", 8'h0F);
   endtask

   task automatic t_map_R10;
      for (int k = 0; k < 16; k++) begin
         cfg_load(8'(k), 1'b0);
         check_state("R10 sector span", 8'(k));
      end
   endtask

   initial begin
      t_reset_R1();
      t_load_R6_R9();
      t_size_R4();
      t_open_R3();
      t_indep_R5();
      t_gap_R2();
      t_bypass_R6();
      t_fault_R7();
      t_collide_R8();
      t_map_R10();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule